// File: doc/BRIEF.md
# Presettable Periodic Timer Interrupt

This block is a down-counting interval timer. It counts falling edges of one slow tick, chosen from several ticks supplied from outside, and pulls an active-low interrupt line when its count runs out. A host programs it through a narrow register port. The port has an address, a 4-bit data bus and an active-low write strobe. Writes take effect on the strobe's rising edge, and reads are combinational from the address.

An 8-bit preset is written as two nibbles. Each nibble write also loads the live counter. When the counter steps from one to zero, the block raises a sticky flag and reloads the preset, so interrupts repeat every preset ticks. Starting and stopping are aligned to the selected tick. When the timer is stopped, one more tick can still decrement the count and raise the flag. The interrupt-enable bit lets the host mask that event.

The timer's internal logic runs on one system clock. The ticks pass through a configurable synchronizer before the edge detector.

Top module: `ptimer_top`

## Requirements
- R1: After reset, the counter, both preset nibbles, the control bits and the tick select read as 0, and `irq_n` is high.
- R2: Address 0 holds the preset's low nibble and address 1 its high nibble, and together they form one 8-bit value. Each reads back the last value written, whether or not the timer runs, so both serve as plain storage.
- R3: A write to address 0 or 1 loads the counter at once with the combined 8-bit preset that includes the new nibble.
- R4: Address 2 reads the counter's low nibble and address 3 its high nibble, at any time, including while the timer counts.
- R5: Control is at address 4: bit 0 is run, bit 1 is interrupt enable, and bit 2 is the flag. Writing run=1 from idle starts the timer. The first falling edge of the selected tick after that write does the first decrement. Tick edges while idle change nothing.
- R6: A tick edge while counting with count 1 sets the flag and reloads the preset. With a count above 1, the edge decrements the count by one.
- R7: A count of 0 with run set stays 0 on tick edges and never sets the flag.
- R8: Writing run=0 to a running timer lets exactly one further selected tick edge act, with normal decrement, reload and flag behaviour. Later edges are ignored.
- R9: `irq_n` is low exactly while flag and interrupt enable are both 1. Writing control with bit 2 = 0 clears the flag. Writing it with bit 2 = 1 leaves the flag unchanged.
- R10: Address 5 bits [1:0] pick the tick source. The choice is taken only when the timer starts from idle, and edges on any other tick are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Active-low write strobe, acts on rising edge |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data |
| src_tick | input | 4 | Candidate tick sources, counted on falling edge |
| rdata | output | 4 | Read data for `addr` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the top with its defaults: an 8-bit count split into 4-bit nibbles, four tick sources and two synchronizer stages. Random presets mostly keep the high nibble at 0 or 1, so that reloads, flag setting and the zero-preset case come up often within a few hundred tick edges. Tick pulses last several system clocks, which places each edge clearly after the synchronizer delay. Source select is changed both while idle and while counting, which exercises the rule that the choice is taken only at start.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   localparam int ADDR_W = 4;
   localparam logic [ADDR_W-1:0] A_PRE_LO = 4'd0;
   localparam logic [ADDR_W-1:0] A_PRE_HI = 4'd1;
   localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd2;
   localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd3;
   localparam logic [ADDR_W-1:0] A_CTRL   = 4'd4;
   localparam logic [ADDR_W-1:0] A_SEL    = 4'd5;
   localparam int B_RUN  = 0;
   localparam int B_IEN  = 1;
   localparam int B_FLAG = 2;
   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_STOP} tmr_state_e;
endpackage

// File: rtl/ptmr_regif.sv
module ptmr_regif
   import ptmr_pkg::*;
#(
   parameter int NIB_W = 4,
   parameter int SEL_W = 2,
   localparam int CNT_W = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NIB_W-1:0]  wdata,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              flag_set_i,
   output logic [CNT_W-1:0]  preset_o,
   output logic [CNT_W-1:0]  load_val_o,
   output logic              load_o,
   output logic              start_o,
   output logic              stop_o,
   output logic              ien_o,
   output logic              flag_o,
   output logic [SEL_W-1:0]  sel_o,
   output logic [NIB_W-1:0]  rdata
);
   generate
      if (NIB_W < 3) begin : g_bad_nib
         $error("ptmr_regif: NIB_W must hold the three control bits");
      end
      if (SEL_W > NIB_W) begin : g_bad_sel
         $error("ptmr_regif: SEL_W wider than the data bus");
      end
   endgenerate

   logic wr_q;
   logic wr_pulse;
   logic run_q;
   logic flag_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_q <= 1'b1;
      else        wr_q <= wr_n;
   end

   assign wr_pulse = wr_n & ~wr_q;
   assign load_o   = wr_pulse && (addr == A_PRE_LO || addr == A_PRE_HI);
   assign start_o  = wr_pulse && addr == A_CTRL && wdata[B_RUN];
   assign stop_o   = wr_pulse && addr == A_CTRL && !wdata[B_RUN];
   assign flag_clr = wr_pulse && addr == A_CTRL && !wdata[B_FLAG];

   always_comb begin
      load_val_o = preset_o;
      if (addr == A_PRE_LO) load_val_o[NIB_W-1:0]     = wdata;
      else                  load_val_o[CNT_W-1:NIB_W] = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preset_o <= '0;
         run_q    <= 1'b0;
         ien_o    <= 1'b0;
         flag_o   <= 1'b0;
         sel_o    <= '0;
      end else begin
         if (load_o) preset_o <= load_val_o;
         if (wr_pulse && addr == A_CTRL) begin
            run_q <= wdata[B_RUN];
            ien_o <= wdata[B_IEN];
         end
         if (wr_pulse && addr == A_SEL) sel_o <= wdata[SEL_W-1:0];
         if (flag_set_i)    flag_o <= 1'b1;
         else if (flag_clr) flag_o <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_PRE_LO: rdata = preset_o[NIB_W-1:0];
         A_PRE_HI: rdata = preset_o[CNT_W-1:NIB_W];
         A_CNT_LO: rdata = cnt_i[NIB_W-1:0];
         A_CNT_HI: rdata = cnt_i[CNT_W-1:NIB_W];
         A_CTRL: begin
            rdata[B_RUN]  = run_q;
            rdata[B_IEN]  = ien_o;
            rdata[B_FLAG] = flag_o;
         end
         A_SEL:   rdata[SEL_W-1:0] = sel_o;
         default: rdata = '0;
      endcase
   end

   AST_PRESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_o |=> $stable(preset_o)) else $error("preset changed without write"); // R2
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !flag_clr) |=> flag_o) else $error("flag dropped"); // R9
endmodule

// File: rtl/ptmr_tick_sel.sv
module ptmr_tick_sel #(
   parameter int N_SRC       = 4,
   parameter int SEL_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] tick_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             latch_i,
   output logic             fall_o
);
   localparam int PAD_W = 1 << SEL_W;

   generate
      if (N_SRC > PAD_W) begin : g_bad_src
         $error("ptmr_tick_sel: select too narrow for N_SRC");
      end
   endgenerate

   logic [N_SRC-1:0] lvl;
   logic [N_SRC-1:0] lvl_q;
   logic [SEL_W-1:0] sel_q;
   logic [PAD_W-1:0] fall_pad;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = tick_i;
      end else begin : g_sync
         logic [N_SRC-1:0] stg_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < SYNC_STAGES; k++) stg_q[k] <= '1;
            end else begin
               stg_q[0] <= tick_i;
               for (int k = 1; k < SYNC_STAGES; k++) stg_q[k] <= stg_q[k-1];
            end
         end
         assign lvl = stg_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '1;
         sel_q <= '0;
      end else begin
         lvl_q <= lvl;
         if (latch_i) sel_q <= sel_i;
      end
   end

   always_comb begin
      fall_pad = '0;
      fall_pad[N_SRC-1:0] = lvl_q & ~lvl;
   end
   assign fall_o = fall_pad[sel_q];

   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_i |=> $stable(sel_q)) else $error("select moved outside start"); // R10
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
   import ptmr_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [CNT_W-1:0] preset_i,
   input  logic             fall_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             flag_set_o,
   output logic             latch_sel_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   tmr_state_e st_q, st_n;
   logic       step;

   assign step        = fall_i && st_q != ST_IDLE;
   assign latch_sel_o = start_i && st_q == ST_IDLE;
   assign flag_set_o  = step && !load_i && cnt_o == ONE;

   always_comb begin
      st_n = st_q;
      if (step && st_q == ST_STOP) st_n = ST_IDLE;
      if (start_i)                        st_n = ST_RUN;
      else if (stop_i && st_n != ST_IDLE) st_n = ST_STOP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_o <= '0;
      end else begin
         st_q <= st_n;
         if (load_i)             cnt_o <= load_val_i;
         else if (step) begin
            if (cnt_o == ONE)    cnt_o <= preset_i;
            else if (cnt_o != 0) cnt_o <= cnt_o - ONE;
         end
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !load_i) |=> $stable(cnt_o)) else $error("idle count moved"); // R5
   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load_i && cnt_o == ONE) |=> cnt_o == $past(preset_i)) else $error("no reload"); // R6
   AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load_i && cnt_o == 0) |=> cnt_o == 0) else $error("zero count moved"); // R7
   AST_STOP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_STOP && step && !start_i) |=> st_q == ST_IDLE) else $error("stop overran"); // R8
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
   import ptmr_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int NIB_W       = 4,
   parameter int N_SRC       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = (N_SRC < 2) ? 1 : $clog2(N_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NIB_W-1:0]  wdata,
   input  logic [N_SRC-1:0]  src_tick,
   output logic [NIB_W-1:0]  rdata,
   output logic              irq_n
);
   generate
      if (CNT_W != 2 * NIB_W) begin : g_bad_cnt
         $error("ptimer_top: CNT_W must be two nibbles");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, preset, load_val;
   logic             load, start, stop, ien, flag, flag_set, latch_sel, fall;
   logic [SEL_W-1:0] sel;

   ptmr_regif #(.NIB_W(NIB_W), .SEL_W(SEL_W)) i_regif (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
      .cnt_i(cnt), .flag_set_i(flag_set), .preset_o(preset),
      .load_val_o(load_val), .load_o(load), .start_o(start), .stop_o(stop),
      .ien_o(ien), .flag_o(flag), .sel_o(sel), .rdata(rdata));

   ptmr_tick_sel #(.N_SRC(N_SRC), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) i_tick (
      .clk(clk), .rst_n(rst_n), .tick_i(src_tick), .sel_i(sel),
      .latch_i(latch_sel), .fall_o(fall));

   ptmr_core #(.CNT_W(CNT_W)) i_core (
      .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .load_i(load),
      .load_val_i(load_val), .preset_i(preset), .fall_i(fall), .cnt_o(cnt),
      .flag_set_o(flag_set), .latch_sel_o(latch_sel));

   assign irq_n = ~(flag & ien);

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !ien |-> irq_n) else $error("irq while masked"); // R9
endmodule

// File: tb/test_ptimer_top.sv
`timescale 1ns/1ps
module test_ptimer_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_n = 1'b1;
   logic [3:0] addr = '0;
   logic [3:0] wdata = '0;
   logic [3:0] src_tick = '1;
   logic [3:0] rdata;
   logic       irq_n;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   // model state: 0 idle, 1 counting, 2 stopping
   int m_pre = 0, m_cnt = 0, m_st = 0, m_sel = 0, m_act = 0;
   bit m_run = 0, m_ien = 0, m_flag = 0;

   always #2.5 clk = ~clk;

   ptimer_top i_ptimer_top (.clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr),
      .wdata(wdata), .src_tick(src_tick), .rdata(rdata), .irq_n(irq_n));

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      addr = 4'(a);
      #1 v = int'(rdata);
   endtask

   function automatic int exp_irq();
      return (m_flag && m_ien) ? 0 : 1;
   endfunction

   task automatic wr(input int a, input int d);
      @(negedge clk);
      addr = 4'(a); wdata = 4'(d); wr_n = 1'b0;
      repeat (2) @(negedge clk);
      wr_n = 1'b1;
      repeat (2) @(negedge clk);
      case (a)
         0: begin m_pre = (m_pre & 8'hF0) | d; m_cnt = m_pre; end
         1: begin m_pre = (m_pre & 8'h0F) | (d << 4); m_cnt = m_pre; end
         4: begin
            m_run = d[0]; m_ien = d[1];
            if (!d[2]) m_flag = 0;
            if (d[0]) begin
               if (m_st == 0) m_act = m_sel;
               m_st = 1;
            end else if (m_st != 0) m_st = 2;
         end
         5: m_sel = d & 3;
         default: ;
      endcase
   endtask

   task automatic tick(input int i);
      @(negedge clk);
      src_tick[i] = 1'b0;
      repeat (8) @(negedge clk);
      src_tick[i] = 1'b1;
      repeat (8) @(negedge clk);
      if (m_st != 0 && i == m_act) begin
         if (m_cnt == 1) begin m_cnt = m_pre; m_flag = 1; end
         else if (m_cnt != 0) m_cnt--;
         if (m_st == 2) m_st = 0;
      end
   endtask

   task automatic check_all(string req);
      int lo, hi, c;
      rd(2, lo); rd(3, hi);
      chk({req, " count"}, (hi << 4) | lo, m_cnt);
      rd(4, c);
      chk({req, " ctrl"}, c, (int'(m_flag) << 2) | (int'(m_ien) << 1) | int'(m_run));
      chk({req, " irq_n"}, int'(irq_n), exp_irq());
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int v, lo, hi;
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      check_all("R1");
      rd(0, v); chk("R1 pre lo", v, 0);
      rd(5, v); chk("R1 sel", v, 0);

      // R2 storage, R3 load, R4 readback
      wr(0, 5); wr(1, 4'hA);
      rd(0, lo); chk("R2 pre lo", lo, 5);
      rd(1, hi); chk("R2 pre hi", hi, 4'hA);
      check_all("R3");

      // R5 start alignment, R10 other source ignored
      wr(0, 3); wr(1, 0);
      tick(0); check_all("R5 idle tick");
      wr(4, 3);
      tick(1); check_all("R10 unselected");
      tick(0); check_all("R5 first step");
      chk("R4 live count", m_cnt, 2);
      tick(0); check_all("R6 down");
      tick(0); check_all("R6 reload");
      chk("R6 irq low", int'(irq_n), 0);

      // R9 flag write semantics
      wr(4, 7); check_all("R9 keep");
      wr(4, 3); check_all("R9 clear");

      // R8 stop slip
      wr(4, 2);
      tick(0); check_all("R8 last step");
      tick(0); check_all("R8 halted");

      // R7 zero preset
      wr(0, 0); wr(1, 0); wr(4, 3);
      tick(0); tick(0); check_all("R7 zero");
      wr(4, 2); tick(0);

      // R10 select latched at start only
      wr(0, 4); wr(5, 2); wr(4, 3);
      tick(0); check_all("R10 old src");
      tick(2); check_all("R10 new src");
      wr(5, 1);
      tick(1); check_all("R10 no switch");
      tick(2); check_all("R10 kept");
      wr(4, 2); tick(2);
      rd(5, v); chk("R10 sel read", v, 1);

      // constrained random
      for (int n = 0; n < 300; n++) begin
         int op;
         op = int'($urandom % 10);
         case (op)
            0: wr(0, int'($urandom % 16));
            1: wr(1, int'($urandom % 2));
            2, 3: wr(4, int'($urandom % 8));
            4: wr(5, int'($urandom % 4));
            default: tick(int'($urandom % 4));
         endcase
         check_all("R6 random");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule